// File: doc/BRIEF.md
# Two-Port Alternating Sample Loader for a High-Rate Converter

This block feeds a fast digital-to-analog converter core from two parallel sample ports, so each port carries half of the output rate. The external sample clock stores one word from port A on its rising edge and one word from port B on its falling edge. Together these two words form a sample pair. The pair is then moved onto an internal clock that runs at twice the external rate and keeps a fixed phase to it. There the pair is shown to the core as A, then B, each for exactly one internal clock period.

Every output slot lasts one period of the doubled clock. The spacing of the interleaved words therefore comes from that clock alone, and errors in the external clock's high and low times do not change it. A slot flag travels with the output word and tells the core which half of the pair is on the bus. Until the first complete pair after reset has arrived, the output bus stays at zero. An optional output register adds one internal cycle of latency and gives the core a flop-driven bus.

Top module: `dacpp_loader`

## Requirements
- R1: The word on `a_in` is stored at each rising edge of `clk_ext`, and the word on `b_in` is stored at each falling edge. Values on either port between their own capture edges have no effect.
- R2: Once output is live, `dac_word` shows the A word for exactly one `clk_2x` period with `dac_sel` = 0. It then shows the B word of the same pair for exactly one period with `dac_sel` = 1. The two strictly alternate.
- R3: With `OUT_REG` = 0, each captured word appears on `dac_word` from the third `clk_2x` rising edge after its own capture edge. With `OUT_REG` = 1, it appears from the fourth.
- R4: While `rst_n` is low, `dac_word` is zero and `dac_sel` is 0.
- R5: After reset, `dac_word` stays zero until a full pair has been taken. A full pair is a rising-edge A capture followed by the next falling-edge B capture. A falling edge that comes before any rising edge since reset does not start a pair.
- R6: The output sequence and its timing do not depend on the high time of `clk_ext`, as long as each `clk_2x` rising edge follows an external edge and comes before the next one.
- R7: `dac_sel` is never 1 for two `clk_2x` cycles in a row.
- R8: `WIDTH` must lie in 2..32 and `OUT_REG` in 0..1. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ext | input | 1 | External sample clock; A is captured on its rise, B on its fall |
| clk_2x | input | 1 | Internal clock at twice the external rate, rising a fixed delay after each external edge |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_in | input | WIDTH | Sample port A |
| b_in | input | WIDTH | Sample port B |
| dac_word | output | WIDTH | Word presented to the converter core |
| dac_sel | output | 1 | Slot of `dac_word`: 0 = A, 1 = B |

## Verification
The bench builds two copies side by side on the same inputs, both with `WIDTH` = 14. One has `OUT_REG` = 0 and the other `OUT_REG` = 1, so both generate branches and both latencies are compared against the same expected stream. The external high time is changed between 16 ns and 24 ns of a 40 ns period to show that the output spacing stays the same. Reset is released once while the external clock is high, so that an orphan falling-edge capture must not form a pair. Full-scale and walking-one patterns check every bit position on both ports.

// File: rtl/dacpp_pkg.sv
package dacpp_pkg;

   // Which half of a sample pair is on the output bus.
   typedef enum logic {
      SLOT_A = 1'b0,
      SLOT_B = 1'b1
   } slot_e;

   function automatic slot_e slot_next(input slot_e cur);
      return (cur == SLOT_A) ? SLOT_B : SLOT_A;
   endfunction

endpackage

// File: rtl/dacpp_capture.sv
// External-domain front end: port A on the rising edge, port B on the falling
// edge, plus a toggle that flips once per complete pair.
module dacpp_capture #(
   parameter int WIDTH = 14
) (
   input  logic             clk_ext,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_q,
   output logic [WIDTH-1:0] b_q,
   output logic             pair_tgl
);

   logic a_taken;

   // R1: rising-edge capture of port A
   always_ff @(posedge clk_ext or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         a_taken <= 1'b0;
      end else begin
         a_q     <= a_in;
         a_taken <= 1'b1;
      end
   end

   // R1/R5: falling-edge capture of port B; a pair is only marked complete
   // when an A word has been stored since reset.
   always_ff @(negedge clk_ext or negedge rst_n) begin
      if (!rst_n) begin
         b_q      <= '0;
         pair_tgl <= 1'b0;
      end else begin
         b_q <= b_in;
         if (a_taken) begin
            pair_tgl <= ~pair_tgl;
         end
      end
   end

endmodule

// File: rtl/dacpp_retime.sv
// Doubled-clock domain: detects each new pair, moves it through two register
// stages and runs the A/B slot flag.
module dacpp_retime
   import dacpp_pkg::*;
#(
   parameter int WIDTH = 14
) (
   input  logic             clk_2x,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_q,
   input  logic [WIDTH-1:0] b_q,
   input  logic             pair_tgl,
   output logic [WIDTH-1:0] hold_a,
   output logic [WIDTH-1:0] hold_b,
   output slot_e            slot,
   output logic             live
);

   logic             tgl_seen;
   logic             new_pair;
   logic             load_hold;
   logic [WIDTH-1:0] stage_a;
   logic [WIDTH-1:0] stage_b;

   assign new_pair = (pair_tgl != tgl_seen);

   // Stage 1: take the pair in the cycle its toggle is first seen.
   always_ff @(posedge clk_2x or negedge rst_n) begin
      if (!rst_n) begin
         tgl_seen  <= 1'b0;
         load_hold <= 1'b0;
         stage_a   <= '0;
         stage_b   <= '0;
      end else begin
         tgl_seen  <= pair_tgl;
         load_hold <= new_pair;
         if (new_pair) begin
            stage_a <= a_q;
            stage_b <= b_q;
         end
      end
   end

   // Stage 2 and slot flag: each load restarts the pair on slot A, otherwise
   // the flag flips every cycle.
   always_ff @(posedge clk_2x or negedge rst_n) begin
      if (!rst_n) begin
         hold_a <= '0;
         hold_b <= '0;
         slot   <= SLOT_A;
         live   <= 1'b0;
      end else if (load_hold) begin
         hold_a <= stage_a;
         hold_b <= stage_b;
         slot   <= SLOT_A;
         live   <= 1'b1;
      end else begin
         slot   <= slot_next(slot);
      end
   end

endmodule

// File: rtl/dacpp_slot_mux.sv
// Chooses the held word for the current slot; zero until a pair is live.
module dacpp_slot_mux
   import dacpp_pkg::*;
#(
   parameter int WIDTH = 14
) (
   input  logic [WIDTH-1:0] hold_a,
   input  logic [WIDTH-1:0] hold_b,
   input  slot_e            slot,
   input  logic             live,
   output logic [WIDTH-1:0] word
);

   always_comb begin
      if (!live) begin
         word = '0;
      end else if (slot == SLOT_B) begin
         word = hold_b;
      end else begin
         word = hold_a;
      end
   end

endmodule

// File: rtl/dacpp_loader.sv
module dacpp_loader
   import dacpp_pkg::*;
#(
   parameter int WIDTH   = 14,
   parameter int OUT_REG = 0
) (
   input  logic             clk_ext,
   input  logic             clk_2x,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] dac_word,
   output logic             dac_sel
);

   localparam int LATENCY_2X = 3 + OUT_REG;

   // R8: elaboration-time parameter checks
   generate
      if (WIDTH < 2 || WIDTH > 32) begin : g_bad_width
         $error("dacpp_loader: WIDTH must be 2..32");
      end
      if (OUT_REG < 0 || OUT_REG > 1) begin : g_bad_outreg
         $error("dacpp_loader: OUT_REG must be 0 or 1");
      end
      if (LATENCY_2X < 3) begin : g_bad_latency
         $error("dacpp_loader: latency below three cycles");
      end
   endgenerate

   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   logic             pair_tgl;
   logic [WIDTH-1:0] hold_a;
   logic [WIDTH-1:0] hold_b;
   slot_e            slot;
   logic             live;
   logic [WIDTH-1:0] mux_word;
   logic             out_live;

   dacpp_capture #(.WIDTH(WIDTH)) i_capture (
      .clk_ext  (clk_ext),
      .rst_n    (rst_n),
      .a_in     (a_in),
      .b_in     (b_in),
      .a_q      (a_q),
      .b_q      (b_q),
      .pair_tgl (pair_tgl)
   );

   dacpp_retime #(.WIDTH(WIDTH)) i_retime (
      .clk_2x   (clk_2x),
      .rst_n    (rst_n),
      .a_q      (a_q),
      .b_q      (b_q),
      .pair_tgl (pair_tgl),
      .hold_a   (hold_a),
      .hold_b   (hold_b),
      .slot     (slot),
      .live     (live)
   );

   dacpp_slot_mux #(.WIDTH(WIDTH)) i_mux (
      .hold_a (hold_a),
      .hold_b (hold_b),
      .slot   (slot),
      .live   (live),
      .word   (mux_word)
   );

   // R3: output stage variant chosen by OUT_REG
   generate
      if (OUT_REG == 1) begin : g_out_reg
         logic [WIDTH-1:0] word_q;
         logic             sel_q;
         logic             live_q;
         always_ff @(posedge clk_2x or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
               sel_q  <= 1'b0;
               live_q <= 1'b0;
            end else begin
               word_q <= mux_word;
               sel_q  <= (slot == SLOT_B);
               live_q <= live;
            end
         end
         assign dac_word = word_q;
         assign dac_sel  = sel_q;
         assign out_live = live_q;
      end else begin : g_out_comb
         assign dac_word = mux_word;
         assign dac_sel  = (slot == SLOT_B);
         assign out_live = live;
      end
   endgenerate

endmodule

// File: rtl/dacpp_loader_chk.sv
module dacpp_loader_chk #(
   parameter int WIDTH = 14
) (
   input logic             clk_2x,
   input logic             rst_n,
   input logic [WIDTH-1:0] dac_word,
   input logic             dac_sel,
   input logic             out_live
);

   // R7
   b_single_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      dac_sel |=> !dac_sel);

   // R2
   a_single_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      (out_live && !dac_sel) |=> dac_sel);

   // R5
   zero_idle_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      !out_live |-> (dac_word == '0));

   // R5
   live_sticky_chk: assert property (@(posedge clk_2x) disable iff (!rst_n)
      out_live |=> out_live);

endmodule

bind dacpp_loader dacpp_loader_chk #(.WIDTH(WIDTH)) i_loader_chk (
   .clk_2x   (clk_2x),
   .rst_n    (rst_n),
   .dac_word (dac_word),
   .dac_sel  (dac_sel),
   .out_live (out_live)
);

// File: tb/test_dacpp_loader.sv
`timescale 1ns/1ps
module test_dacpp_loader;

   localparam int W = 14;

   logic         clk_ext = 1'b0;
   logic         clk_2x  = 1'b0;
   logic         rst_n   = 1'b0;
   logic [W-1:0] a_in    = '0;
   logic [W-1:0] b_in    = '0;
   logic [W-1:0] word0, word1;
   logic         sel0, sel1;
   int           ext_hi  = 20;
   int           checks  = 0;
   int           errors  = 0;
   logic [W-1:0] pa [0:19];
   logic [W-1:0] pb [0:19];

   dacpp_loader #(.WIDTH(W), .OUT_REG(0)) i_dacpp_loader (
      .clk_ext(clk_ext), .clk_2x(clk_2x), .rst_n(rst_n),
      .a_in(a_in), .b_in(b_in), .dac_word(word0), .dac_sel(sel0));

   dacpp_loader #(.WIDTH(W), .OUT_REG(1)) i_dacpp_loader_q (
      .clk_ext(clk_ext), .clk_2x(clk_2x), .rst_n(rst_n),
      .a_in(a_in), .b_in(b_in), .dac_word(word1), .dac_sel(sel1));

   // 50 MHz internal clock, rising 5 ns after every external edge.
   initial begin
      #5;
      forever begin
         clk_2x = 1'b1; #10;
         clk_2x = 1'b0; #10;
      end
   end

   // 25 MHz external clock with adjustable high time.
   initial begin
      #20;
      forever begin
         clk_ext = 1'b1; #(ext_hi * 1ns);
         clk_ext = 1'b0; #((40 - ext_hi) * 1ns);
      end
   end

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] pat(input int kind, input int idx, input bit is_b);
      logic [W-1:0] one;
      one = W'(1) << (idx % W);
      case (kind)
         1:       return ((idx % 2 == 0) ^ is_b) ? {W{1'b1}} : '0;
         2:       return is_b ? ~one : one;
         default: return W'(idx * 613 + (is_b ? 4099 : 17));
      endcase
   endfunction

   task automatic fill(input int kind);
      for (int i = 0; i < 20; i++) begin
         pa[i] = pat(kind, i, 1'b0);
         pb[i] = pat(kind, i, 1'b1);
      end
   endtask

   // Reset; release either while the external clock is low (+30 ns after a
   // rise) or while it is high (+10 ns, before the falling edge).
   task automatic do_reset(input bit late);
      rst_n = 1'b0;
      a_in  = pa[0];
      b_in  = {W/2{2'b10}};
      @(posedge clk_ext);
      #8;
      chk("R4 word", word0, '0);
      chk("R4 sel", {{(W-1){1'b0}}, sel0}, '0);
      chk("R4 word q", word1, '0);
      if (late) begin
         #2 rst_n = 1'b1;
      end else begin
         #22 rst_n = 1'b1;
      end
   endtask

   function automatic logic [W-1:0] ga(input int i);
      return (i < 0) ? '0 : pa[i];
   endfunction
   function automatic logic [W-1:0] gb(input int i);
      return (i < 0) ? '0 : pb[i];
   endfunction

   // Pair j: A stored at rise j, B at fall j. Samples at rise+15 and rise+35.
   task automatic stream(input int n, input string tag);
      for (int j = 0; j <= n + 1; j++) begin
         @(posedge clk_ext);
         #2;
         a_in = pa[j + 1];
         b_in = pb[j];
         #13;
         // R3: comb output shows A(j-1); registered shows B(j-2)
         chk({tag, " R3 A slot"}, word0, ga(j - 1));
         chk({tag, " R3 q B slot"}, word1, gb(j - 2));
         if (j >= 1) chk({tag, " R2 sel A"}, {{(W-1){1'b0}}, sel0}, '0);
         if (j >= 2) chk({tag, " R2 q sel B"}, {{(W-1){1'b0}}, sel1}, W'(1));
         #20;
         chk({tag, " R3 B slot"}, word0, gb(j - 1));
         chk({tag, " R3 q A slot"}, word1, ga(j - 1));
         if (j >= 1) chk({tag, " R2 sel B"}, {{(W-1){1'b0}}, sel0}, W'(1));
         if (j >= 2) chk({tag, " R2 q sel A"}, {{(W-1){1'b0}}, sel1}, '0);
      end
   endtask

   task automatic t_basic();       // R1 R2 R3 R5
      ext_hi = 20; fill(0); do_reset(1'b0); stream(8, "basic");
   endtask

   task automatic t_extremes();    // R1 R3 full-scale and walking bits
      ext_hi = 20; fill(1); do_reset(1'b0); stream(6, "fullscale");
      fill(2); do_reset(1'b0); stream(14, "walk");
   endtask

   task automatic t_duty();        // R6
      ext_hi = 16; fill(0); do_reset(1'b0); stream(6, "R6 short-high");
      ext_hi = 24; fill(2); do_reset(1'b0); stream(6, "R6 long-high");
   endtask

   task automatic t_late_reset();  // R5 orphan falling edge ignored
      ext_hi = 20; fill(0); do_reset(1'b1); stream(5, "R5 late release");
   endtask

   bit done = 1'b0;

   initial begin
      #200_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      t_basic();
      t_extremes();
      t_duty();
      t_late_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule